// File: doc/BRIEF.md
# Two-Wire Sensor Register Slave

This block is the bus-facing side of an on-chip temperature sensor. It sits on a two-wire serial bus (I2C/SMBus style) as a slave and gives a host access to a small file of 16-bit registers: the live temperature word, a configuration word and a pair of limit words. The raw SCL and SDA levels are sampled with a fast system clock through synchronizers. Start and stop conditions are decoded from the sampled levels, and SDA is pulled low through an open-drain enable output.

The host first writes a pointer byte, and the low three bits of that byte choose the target register. Data bytes that follow the pointer in the same write go into that register, upper byte first. A read transaction returns the register named by the last pointer write, upper byte first. The host does not need to resend the pointer before a read. The word is frozen when the read starts, so the two halves always belong together.

The block has three outputs towards the rest of the sensor. The configuration and limit words go to the sensor logic. A one-cycle strobe fires when the one-shot register is written. A one-cycle strobe fires at the start of every read, and the alert logic uses it to clear a latched alert. A watchdog on the bus lines returns the slave to idle if either line stays low too long during a transaction.

Top module: `twi_sensor_regs`

## Requirements
- R1: The slave answers only the 7-bit address formed by the prefix 1001 (upper four bits) followed by `addrPins[2:0]`, with `addrPins` sampled at each start condition. An address byte that does not match gets no acknowledge, and every later byte up to the next start is ignored and not acknowledged.
- R2: The first byte after an acknowledged write address is the pointer. Only its low three bits are kept. The pointer lasts across transactions until it is written again, and a read with no pointer byte uses the stored value.
- R3: Pointer values select 0 = temperature (read only, writes ignored), 1 = configuration, 2 = low limit, 3 = high limit, 4 = one-shot (write only, reads 0000h). Pointer values 5 to 7 read 0000h and ignore writes.
- R4: The first data byte of a write goes to bits 15:8 of the selected register and the second goes to bits 7:0. A write that ends after one data byte changes only bits 15:8. A third or later data byte is acknowledged and discarded.
- R5: A read sends bits 15:8 first, then bits 7:0, each byte MSB first. Further bytes alternate upper and lower. The word is captured when the read address is acknowledged, so a change of `tempWord` during the read does not affect the bytes of that read.
- R6: A not-acknowledge from the master after a read byte ends the read. From then on the slave leaves SDA released until the next start.
- R7: A first byte 00001xxx (high-speed master code) gets no acknowledge, and the slave stays idle until the next start.
- R8: If SCL or SDA stays low for `TIMEOUT_CYC` consecutive system clocks between a start and a stop, the slave releases SDA and waits for a new start.
- R9: After reset the pointer is 0, configuration is 0000h, the low limit is 4B00h and the high limit is 5000h, and SDA is released.
- R10: `oneShotPulse` is high for exactly one clock when a write transaction with pointer 4 delivers its first data byte. No other write produces it.
- R11: `regReadPulse` is high for exactly one clock each time a read address is acknowledged.
- R12: The slave pulls SDA low only while it acknowledges an address byte or a write byte, or while it sends a 0 bit of read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw level of the SCL line |
| sdaIn | input | 1 | Raw level of the SDA line |
| addrPins | input | 3 | Strapped low bits of the slave address |
| tempWord | input | 16 | Current temperature result, left-justified two's complement |
| sdaDrvLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfgWord | output | 16 | Configuration register contents |
| lowLimit | output | 16 | Low limit register contents |
| highLimit | output | 16 | High limit register contents |
| oneShotPulse | output | 1 | One-clock strobe on a one-shot register write |
| regReadPulse | output | 1 | One-clock strobe at the start of each read |

## Verification
The assertions assume a well-behaved master. SDA changes only while SCL is low, except for deliberate start and stop conditions. Every SCL phase lasts several system clocks longer than the three-flop sampling path, and no line stays low long enough to reach the timeout unless a test means to. The bench master holds each SCL half period for 20 clocks and waits 4 clocks after each falling SCL edge before it moves SDA, with the timeout set well above the longest run of low bits in any transfer. The one deliberate violation is the timeout test, where SCL is held low past the limit while the slave is driving a 0.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_TEMP = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CFG  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LOW  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_HIGH = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SHOT = 3'd4;

  // strobes from bus control to register datapath
  typedef struct packed {
    logic              ptrWe;
    logic              hiWe;
    logic              loWe;
    logic              snap;
    logic [BYTE_W-1:0] wrByte;
  } twi_strobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK} twi_state_e;
endpackage

// File: rtl/twi_regfile.sv
`timescale 1ns/1ps
module twi_regfile
  import twi_pkg::*;
#(
  parameter logic [REG_W-1:0] CFG_RST  = 16'h0000,
  parameter logic [REG_W-1:0] LOW_RST  = 16'h4B00,
  parameter logic [REG_W-1:0] HIGH_RST = 16'h5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  twi_strobe_t       strb,
  input  logic [REG_W-1:0]  tempWord,
  output logic [REG_W-1:0]  cfgWord,
  output logic [REG_W-1:0]  lowLimit,
  output logic [REG_W-1:0]  highLimit,
  output logic              oneShot,
  output logic [REG_W-1:0]  readWord
);
  localparam int HB = REG_W - 1;
  localparam int LB = BYTE_W - 1;

  logic [SEL_W-1:0] ptrQ;
  logic [REG_W-1:0] liveWord;

  always_comb begin
    case (ptrQ)
      SEL_TEMP: liveWord = tempWord;
      SEL_CFG:  liveWord = cfgWord;
      SEL_LOW:  liveWord = lowLimit;
      SEL_HIGH: liveWord = highLimit;
      default:  liveWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ      <= SEL_TEMP;
      cfgWord   <= CFG_RST;
      lowLimit  <= LOW_RST;
      highLimit <= HIGH_RST;
      oneShot   <= 1'b0;
      readWord  <= '0;
    end else begin
      oneShot <= 1'b0;
      if (strb.ptrWe) ptrQ <= strb.wrByte[SEL_W-1:0];
      if (strb.hiWe) begin
        case (ptrQ)
          SEL_CFG:  cfgWord[HB:BYTE_W]   <= strb.wrByte;
          SEL_LOW:  lowLimit[HB:BYTE_W]  <= strb.wrByte;
          SEL_HIGH: highLimit[HB:BYTE_W] <= strb.wrByte;
          SEL_SHOT: oneShot              <= 1'b1;
          default:  ;
        endcase
      end
      if (strb.loWe) begin
        case (ptrQ)
          SEL_CFG:  cfgWord[LB:0]   <= strb.wrByte;
          SEL_LOW:  lowLimit[LB:0]  <= strb.wrByte;
          SEL_HIGH: highLimit[LB:0] <= strb.wrByte;
          default:  ;
        endcase
      end
      if (strb.snap) readWord <= liveWord;
    end
  end

  AST_ONESHOT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    oneShot |=> !oneShot); // R10
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ptrWe |=> $stable(ptrQ)); // R2
  AST_LIMITS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.hiWe || strb.loWe) |=> ($stable(lowLimit) && $stable(highLimit) && $stable(cfgWord))); // R4
endmodule

// File: rtl/twi_link.sv
`timescale 1ns/1ps
module twi_link
  import twi_pkg::*;
#(
  parameter int          TIMEOUT_CYC = 4400000,
  parameter logic [3:0]  ADDR_PREFIX = 4'b1001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        addrPins,
  input  logic [REG_W-1:0]  readWord,
  output twi_strobe_t       strb,
  output logic              sdaLow,
  output logic              readPulse
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int HB = REG_W - 1;
  localparam int LB = BYTE_W - 1;
  localparam logic [3:0] LAST_BIT = 4'd8;

  // line sampling: two sync stages plus one history stage
  logic [1:0] syncA, syncB, syncC;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1; syncB <= '1; syncC <= '1;
    end else begin
      syncA <= {sclIn, sdaIn};
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  logic sclS, sdaS, sclP, sdaP;
  assign {sclS, sdaS} = syncB;
  assign {sclP, sdaP} = syncC;

  logic startDet, stopDet, sclRise, sclFall;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;

  twi_state_e        state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shReg, txSh;
  logic [2:0]        addrLat;
  logic              isAddr, isRead, readHi, ackSeen, inTxn;
  logic [1:0]        dataIdx;

  // stuck-line watchdog, one counter per line
  logic [1:0] lineS, lowHit;
  logic       tmoHit;
  assign lineS = {sclS, sdaS};
  for (genvar g = 0; g < 2; g++) begin : g_tmo
    logic [TW-1:0] lowCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      lowCnt <= '0;
      else if (!inTxn || lineS[g])    lowCnt <= '0;
      else if (!lowHit[g])            lowCnt <= lowCnt + TW'(1);
    end
    assign lowHit[g] = (lowCnt == TW'(TIMEOUT_CYC));
  end
  assign tmoHit = |lowHit;

  logic [BYTE_W-1:0] nextByte;
  assign nextByte = readHi ? readWord[HB:BYTE_W] : readWord[LB:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shReg     <= '0;
      txSh      <= '0;
      addrLat   <= '0;
      isAddr    <= 1'b0;
      isRead    <= 1'b0;
      readHi    <= 1'b0;
      ackSeen   <= 1'b0;
      inTxn     <= 1'b0;
      dataIdx   <= '0;
      sdaLow    <= 1'b0;
      readPulse <= 1'b0;
      strb      <= '0;
    end else begin
      strb      <= '0;
      readPulse <= 1'b0;
      if (tmoHit) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
        inTxn  <= 1'b0;
      end else if (startDet) begin
        state   <= ST_RX;
        isAddr  <= 1'b1;
        isRead  <= 1'b0;
        bitCnt  <= '0;
        dataIdx <= '0;
        addrLat <= addrPins;
        sdaLow  <= 1'b0;
        inTxn   <= 1'b1;
      end else if (stopDet) begin
        state  <= ST_IDLE;
        sdaLow <= 1'b0;
        inTxn  <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt != LAST_BIT) begin
              shReg  <= {shReg[BYTE_W-2:0], sdaS};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              if (isAddr) begin
                if (shReg[7:1] == {ADDR_PREFIX, addrLat}) begin
                  sdaLow <= 1'b1;
                  isRead <= shReg[0];
                  state  <= ST_RXACK;
                  if (shReg[0]) begin
                    readPulse <= 1'b1;
                    strb.snap <= 1'b1;
                  end
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sdaLow      <= 1'b1;
                state       <= ST_RXACK;
                strb.wrByte <= shReg;
                case (dataIdx)
                  2'd0:    strb.ptrWe <= 1'b1;
                  2'd1:    strb.hiWe  <= 1'b1;
                  2'd2:    strb.loWe  <= 1'b1;
                  default: ;
                endcase
                if (dataIdx != 2'd3) dataIdx <= dataIdx + 2'd1;
              end
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              isAddr <= 1'b0;
              if (isRead) begin
                txSh   <= readWord[HB:BYTE_W];
                sdaLow <= ~readWord[HB];
                readHi <= 1'b0;
                bitCnt <= 4'd1;
                state  <= ST_TX;
              end else begin
                sdaLow <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                sdaLow  <= 1'b0;
                ackSeen <= 1'b0;
                state   <= ST_TXACK;
              end else begin
                sdaLow <= ~txSh[BYTE_W-2];
                txSh   <= {txSh[BYTE_W-2:0], 1'b0};
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) begin
              if (sdaS) state <= ST_IDLE;
              else      ackSeen <= 1'b1;
            end else if (sclFall && ackSeen) begin
              txSh   <= nextByte;
              sdaLow <= ~nextByte[BYTE_W-1];
              readHi <= ~readHi;
              bitCnt <= 4'd1;
              state  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaLow); // R6
  AST_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RXACK) |-> sdaLow); // R12
  AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX) |-> isRead); // R5
  AST_READ_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    readPulse |=> !readPulse); // R11
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    tmoHit |=> (!sdaLow && state == ST_IDLE)); // R8
endmodule

// File: rtl/twi_sensor_regs.sv
`timescale 1ns/1ps
module twi_sensor_regs
  import twi_pkg::*;
#(
  parameter int               TIMEOUT_CYC = 4400000,
  parameter logic [3:0]       ADDR_PREFIX = 4'b1001,
  parameter logic [REG_W-1:0] CFG_RST     = 16'h0000,
  parameter logic [REG_W-1:0] LOW_RST     = 16'h4B00,
  parameter logic [REG_W-1:0] HIGH_RST    = 16'h5000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  addrPins,
  input  logic [15:0] tempWord,
  output logic        sdaDrvLow,
  output logic [15:0] cfgWord,
  output logic [15:0] lowLimit,
  output logic [15:0] highLimit,
  output logic        oneShotPulse,
  output logic        regReadPulse
);
  twi_strobe_t      strb;
  logic [REG_W-1:0] readWord;

  twi_link #(.TIMEOUT_CYC(TIMEOUT_CYC), .ADDR_PREFIX(ADDR_PREFIX)) link_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrPins(addrPins),
    .readWord(readWord), .strb(strb), .sdaLow(sdaDrvLow), .readPulse(regReadPulse)
  );

  twi_regfile #(.CFG_RST(CFG_RST), .LOW_RST(LOW_RST), .HIGH_RST(HIGH_RST)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .tempWord(tempWord), .cfgWord(cfgWord),
    .lowLimit(lowLimit), .highLimit(highLimit), .oneShot(oneShotPulse), .readWord(readWord)
  );
endmodule

// File: tb/twi_sensor_regs_tb_top.sv
`timescale 1ns/1ps
module twi_sensor_regs_tb_top;
  localparam int HALF = 20;
  localparam int TMO  = 3000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        mScl = 1'b1, mSda = 1'b1;
  logic [2:0]  addrPins = 3'b101;
  logic [15:0] tempWord = 16'h1920;
  logic        sdaDrvLow, oneShotPulse, regReadPulse;
  logic [15:0] cfgWord, lowLimit, highLimit;
  wire         sdaLine = mSda & ~sdaDrvLow;

  twi_sensor_regs #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .addrPins(addrPins),
    .tempWord(tempWord), .sdaDrvLow(sdaDrvLow), .cfgWord(cfgWord), .lowLimit(lowLimit),
    .highLimit(highLimit), .oneShotPulse(oneShotPulse), .regReadPulse(regReadPulse)
  );

  int compared = 0, mismatched = 0;
  int osCnt = 0, rdCnt = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (oneShotPulse) osCnt++;
    if (regReadPulse) rdCnt++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard for read bytes
  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t expQ[$];
  event byteSeen;
  logic [7:0] seenByte;

  initial forever begin
    @(byteSeen);
    if (expQ.size() == 0) chk("unexpected read byte", {8'h00, seenByte}, 16'hxxxx);
    else begin
      exp_t e;
      e = expQ.pop_front();
      chk(e.tag, {8'h00, seenByte}, {8'h00, e.v});
    end
  end

  task automatic pushExp(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(HALF);
    mScl = 1'b1; tick(HALF);
    mSda = 1'b0; tick(HALF);
    mScl = 1'b0; tick(4);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(HALF);
    mScl = 1'b1; tick(HALF);
    mSda = 1'b1; tick(HALF);
  endtask

  task automatic putByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(HALF);
      mScl = 1'b1; tick(HALF);
      mScl = 1'b0; tick(4);
    end
    mSda = 1'b1; tick(HALF);
    mScl = 1'b1; tick(HALF/2);
    ack = sdaLine; tick(HALF/2);
    mScl = 1'b0; tick(4);
  endtask

  task automatic getByte(input logic nack);
    logic [7:0] b;
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      mScl = 1'b1; tick(HALF/2);
      b[i] = sdaLine; tick(HALF/2);
      mScl = 1'b0; tick(4);
    end
    mSda = nack; tick(HALF);
    mScl = 1'b1; tick(HALF);
    mScl = 1'b0; tick(4);
    mSda = 1'b1;
    seenByte = b;
    -> byteSeen;
    tick(2);
  endtask

  // write: n bytes after address (pointer first), each ack compared to expAck
  task automatic wrTxn(input logic [6:0] dev, input logic [7:0] b0, b1, b2, b3,
                       input int n, input logic expAck, input string tag);
    logic ack;
    logic [7:0] bs [4];
    bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
    busStart();
    putByte({dev, 1'b0}, ack);
    chk({tag, " addr ack"}, {15'd0, ack}, {15'd0, expAck});
    for (int k = 0; k < n; k++) begin
      putByte(bs[k], ack);
      chk({tag, " byte ack"}, {15'd0, ack}, {15'd0, expAck});
    end
    busStop();
  endtask

  task automatic rdTxn(input logic [6:0] dev, input int n, input logic [15:0] w, input string tag);
    logic ack;
    busStart();
    putByte({dev, 1'b1}, ack);
    chk({tag, " read addr ack"}, {15'd0, ack}, 16'd0);
    for (int k = 0; k < n; k++) begin
      pushExp((k % 2 == 0) ? w[15:8] : w[7:0], tag);
      getByte(k == n - 1);
    end
    busStop();
  endtask

  initial begin
    int lowSeen;
    int rd0;
    logic ack;
    tick(10);
    // R9 reset state
    chk("R9 cfg reset", cfgWord, 16'h0000);
    chk("R9 low reset", lowLimit, 16'h4B00);
    chk("R9 high reset", highLimit, 16'h5000);
    chk("R9 sda released", {15'd0, sdaDrvLow}, 16'd0);
    rstN = 1'b1;
    tick(10);

    // R2/R5/R11: default pointer reads temperature, MSB byte first
    rdTxn(7'h4D, 2, 16'h1920, "R5 temp default ptr");
    chk("R11 one read pulse", rdCnt, 1);

    // R4/R3 word write to configuration, then R2 read without pointer
    wrTxn(7'h4D, 8'h01, 8'h60, 8'hA5, 8'h00, 3, 1'b0, "R4 cfg write");
    chk("R4 cfg word", cfgWord, 16'h60A5);
    rdTxn(7'h4D, 2, 16'h60A5, "R2 pointer persists");

    // R4 single byte updates upper half only
    wrTxn(7'h4D, 8'h02, 8'h12, 8'h00, 8'h00, 2, 1'b0, "R4 single byte");
    chk("R4 low limit upper only", lowLimit, 16'h1200);

    // R4 extra bytes acknowledged and discarded
    wrTxn(7'h4D, 8'h03, 8'h55, 8'h66, 8'h77, 4, 1'b0, "R4 extra byte");
    chk("R4 high limit", highLimit, 16'h5566);

    // R3 temperature is read only
    wrTxn(7'h4D, 8'h00, 8'hAA, 8'hBB, 8'h00, 3, 1'b0, "R3 temp write");
    rdTxn(7'h4D, 2, 16'h1920, "R3 temp unchanged");
    chk("R10 no one-shot yet", osCnt, 0);

    // R10 one-shot write strobe, R3 one-shot reads zero
    wrTxn(7'h4D, 8'h04, 8'h00, 8'h00, 8'h00, 3, 1'b0, "R10 one-shot write");
    chk("R10 one-shot pulse count", osCnt, 1);
    rdTxn(7'h4D, 2, 16'h0000, "R3 one-shot reads zero");

    // R3 unmapped pointer
    wrTxn(7'h4D, 8'h06, 8'h12, 8'h34, 8'h00, 3, 1'b0, "R3 unmapped write");
    rdTxn(7'h4D, 2, 16'h0000, "R3 unmapped reads zero");
    chk("R3 cfg untouched", cfgWord, 16'h60A5);
    chk("R10 still one pulse", osCnt, 1);

    // R1 wrong address ignored
    wrTxn(7'h48, 8'h01, 8'hFF, 8'hFF, 8'h00, 3, 1'b1, "R1 wrong addr");
    chk("R1 cfg untouched", cfgWord, 16'h60A5);
    addrPins = 3'b000;
    tick(5);
    wrTxn(7'h48, 8'h01, 8'h12, 8'h34, 8'h00, 3, 1'b0, "R1 new pins");
    chk("R1 cfg via new address", cfgWord, 16'h1234);
    wrTxn(7'h4D, 8'h01, 8'hEE, 8'h00, 8'h00, 2, 1'b1, "R1 old address");
    chk("R1 cfg after old address", cfgWord, 16'h1234);

    // R7 high-speed master code not acknowledged, slave idle
    busStart();
    putByte(8'h09, ack);
    chk("R7 master code nack", {15'd0, ack}, 16'd1);
    putByte(8'h90, ack);
    chk("R7 idle until start", {15'd0, ack}, 16'd1);
    putByte(8'h01, ack);
    putByte(8'h00, ack);
    busStop();
    chk("R7 cfg untouched", cfgWord, 16'h1234);

    // R5 repeated start read with alternating bytes
    busStart();
    putByte(8'h90, ack);
    chk("R5 write addr ack", {15'd0, ack}, 16'd0);
    putByte(8'h03, ack);
    busStart();
    putByte(8'h91, ack);
    chk("R5 read addr ack", {15'd0, ack}, 16'd0);
    pushExp(8'h55, "R5 byte1"); getByte(1'b0);
    pushExp(8'h66, "R5 byte2"); getByte(1'b0);
    pushExp(8'h55, "R5 byte3 wraps"); getByte(1'b1);
    busStop();

    // R5 snapshot across bytes
    wrTxn(7'h48, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1'b0, "R5 set ptr");
    rd0 = rdCnt;
    busStart();
    putByte(8'h91, ack);
    pushExp(8'h19, "R5 snapshot msb"); getByte(1'b0);
    tempWord = 16'hE700;
    pushExp(8'h20, "R5 snapshot lsb"); getByte(1'b1);
    busStop();
    rdTxn(7'h48, 2, 16'hE700, "R5 new temp");
    chk("R11 pulse per read", rdCnt - rd0, 2);

    // R6 nack releases the line
    wrTxn(7'h48, 8'h01, 8'h00, 8'h00, 8'h00, 1, 1'b0, "R6 set ptr");
    busStart();
    putByte(8'h91, ack);
    pushExp(8'h12, "R6 msb"); getByte(1'b1);
    lowSeen = 0;
    for (int k = 0; k < 9; k++) begin
      tick(HALF); mScl = 1'b1; tick(HALF/2);
      if (!sdaLine) lowSeen++;
      tick(HALF/2); mScl = 1'b0; tick(4);
    end
    busStop();
    chk("R6 no drive after nack", lowSeen, 0);

    // R8 timeout
    wrTxn(7'h48, 8'h00, 8'h00, 8'h00, 8'h00, 1, 1'b0, "R8 set ptr");
    tempWord = 16'h1920;
    busStart();
    putByte(8'h91, ack);
    tick(10);
    chk("R12 driving msb zero", {15'd0, sdaDrvLow}, 16'd1);
    tick(TMO + 200);
    chk("R8 released after timeout", {15'd0, sdaDrvLow}, 16'd0);
    busStop();
    rdTxn(7'h48, 2, 16'h1920, "R8 usable after timeout");

    tick(20);
    chk("R12 idle released", {15'd0, sdaDrvLow}, 16'd0);
    chk("scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule